// File: doc/BRIEF.md
# Limited-Pointer Coherence Directory Entry

This block keeps the sharing record for one memory line in a directory-based coherence controller. It does not hold a full presence vector with one bit per processor. Instead it stores a small, fixed number of processor identifiers. A read request from a processor that is not yet recorded takes a free pointer slot. A write request returns, one cycle later, the set of processors whose copies must be invalidated. The entry is then reduced to a single record of the writer.

When a read arrives while every pointer slot is taken, the `policy` input picks how the entry overflows:
- **Broadcast:** the entry raises a flag that covers all processors.
- **Evict:** the entry drops its oldest sharer, sends it an invalidation, and reuses that slot.
- **Coarse:** the entry reinterprets its pointer storage as a bit vector in which each bit stands for a group of processors.

The present set, the raw pointer storage, the sharer count and the overflow flags are all visible as readout ports. Data movement and the interconnect belong to neighbouring blocks. The policy is meant to be held constant while the entry is in use, and is changed only under reset.

Top module: `lpd_entry`

## Requirements
- R1: After reset the entry is empty: `sharer_cnt` is 0, both overflow flags are low, `present_mask` is all zero and `inv_valid` is low.
- R2: A read from a processor not in `present_mask`, while a slot is free and no overflow flag is set, stores the id in slot `sharer_cnt` and increments the count, with no invalidation. Slot k occupies `ptr_bits[k*ID_W +: ID_W]`.
- R3: A read from a processor already set in `present_mask` changes neither `ptr_bits` nor the count nor the flags, and raises no invalidation.
- R4: One cycle after a write request, `inv_mask` equals the present set with the writer's bit cleared. `inv_valid` is high exactly when that mask is non-zero.
- R5: After a write, the entry holds only the writer, in slot 0. All other storage is zero, `sharer_cnt` is 1, both flags are low, and the eviction order restarts at slot 0.
- R6: With `policy` = 0 (broadcast), a read miss on a full entry sets `ovf_bcast`. The pointers are kept and `present_mask` becomes all ones, so a later write invalidates every processor except the writer.
- R7: With `policy` = 1 (evict), a read miss on a full entry invalidates exactly one processor, the oldest pointer. The victim slot advances round-robin from slot 0. The new id takes the victim's slot.
- R8: With `policy` = 2 (coarse), a read miss on a full entry sets `ovf_coarse` and rewrites `ptr_bits` so that bit g is set when any sharer or the requester lies in processors g*GRP to g*GRP+GRP-1. GRP is NPROC/(NPTR*ID_W) rounded up to a power of two. Later misses set their group bit.
- R9: In coarse mode a write never invalidates more processors than broadcast mode would for the same entry, that is at most NPROC-1.
- R10: `sharer_cnt` never exceeds NPTR, and at most one overflow flag is set at a time.
- R11: Codes 3 on `policy` behave as broadcast.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| policy | input | 2 | Overflow policy: 0 broadcast, 1 evict oldest, 2 coarse vector, 3 as broadcast |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write request, 0 = read request |
| req_id | input | ID_W | Requesting processor id |
| inv_valid | output | 1 | Invalidation target set is non-empty this cycle |
| inv_mask | output | NPROC | Processors to invalidate |
| sharer_cnt | output | CNT_W | Number of used pointer slots |
| ovf_bcast | output | 1 | Broadcast overflow flag |
| ovf_coarse | output | 1 | Coarse-vector overflow flag |
| ptr_bits | output | NPTR*ID_W | Raw pointer storage, or the coarse vector in coarse mode |
| present_mask | output | NPROC | Processors currently covered by the entry |

## Verification
On a read miss to a full entry, two things happen in the same request: a sharer is added and the overflow is resolved. In evict mode that cycle both retires a victim through `inv_mask` and installs the new pointer. In coarse mode it both packs the old pointers into group bits and sets the requester's group. Directed sequences fill the slots and then miss. Random traffic with a small id range and frequent writes reaches these cycles again and again. A bench model built from the requirements predicts the invalidation set and the whole readout after every request, and that prediction is compared on the cycle after the request.

// File: rtl/lpd_pkg.sv
package lpd_pkg;
  typedef enum logic [1:0] {
    POL_BCAST  = 2'd0,
    POL_EVICT  = 2'd1,
    POL_COARSE = 2'd2
  } pol_e;
endpackage

// File: rtl/lpd_present.sv
module lpd_present #(
  parameter int NPROC   = 16,
  parameter int NPTR    = 2,
  parameter int ID_W    = 4,
  parameter int CNT_W   = 2,
  parameter int GRP_LOG = 1,
  localparam int CV_W   = NPTR * ID_W
) (
  input  logic [CV_W-1:0]  store,
  input  logic [CNT_W-1:0] cnt,
  input  logic             bcast,
  input  logic             coarse,
  output logic [NPROC-1:0] present
);
  function automatic logic ptr_hit(input logic [CV_W-1:0] st, input logic [CNT_W-1:0] c,
                                   input int p);
    logic h;
    h = 1'b0;
    for (int k = 0; k < NPTR; k++)
      if (CNT_W'(k) < c && st[k*ID_W +: ID_W] == ID_W'(p)) h = 1'b1;
    return h;
  endfunction

  for (genvar p = 0; p < NPROC; p++) begin : g_proc
    localparam int G = p >> GRP_LOG;
    assign present[p] = bcast | (coarse & store[G]) |
                        (~bcast & ~coarse & ptr_hit(store, cnt, p));
  end
endmodule

// File: rtl/lpd_update.sv
module lpd_update
  import lpd_pkg::*;
#(
  parameter int NPROC   = 16,
  parameter int NPTR    = 2,
  parameter int ID_W    = 4,
  parameter int CNT_W   = 2,
  parameter int RR_W    = 1,
  parameter int GRP_LOG = 1,
  localparam int CV_W   = NPTR * ID_W
) (
  input  logic [1:0]       policy,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [ID_W-1:0]  req_id,
  input  logic [CV_W-1:0]  store,
  input  logic [CNT_W-1:0] cnt,
  input  logic [RR_W-1:0]  rr,
  input  logic             bcast,
  input  logic             coarse,
  input  logic [NPROC-1:0] present,
  output logic [CV_W-1:0]  n_store,
  output logic [CNT_W-1:0] n_cnt,
  output logic [RR_W-1:0]  n_rr,
  output logic             n_bcast,
  output logic             n_coarse,
  output logic [NPROC-1:0] n_inv,
  output logic             ev_write,
  output logic             ev_hit,
  output logic             ev_add,
  output logic             ev_evict,
  output logic             ev_ovf
);
  function automatic logic [NPROC-1:0] onehot(input logic [ID_W-1:0] id);
    logic [NPROC-1:0] m;
    m = '0;
    m[id] = 1'b1;
    return m;
  endfunction

  function automatic logic [CV_W-1:0] coarse_pack(input logic [NPROC-1:0] pres,
                                                  input logic [ID_W-1:0] id);
    logic [CV_W-1:0] v;
    v = '0;
    for (int p = 0; p < NPROC; p++)
      if (pres[p] || id == ID_W'(p)) v[p >> GRP_LOG] = 1'b1;
    return v;
  endfunction

  always_comb begin
    n_store  = store;
    n_cnt    = cnt;
    n_rr     = rr;
    n_bcast  = bcast;
    n_coarse = coarse;
    n_inv    = '0;
    ev_write = 1'b0;
    ev_hit   = 1'b0;
    ev_add   = 1'b0;
    ev_evict = 1'b0;
    ev_ovf   = 1'b0;
    if (req_valid) begin
      if (req_write) begin
        ev_write = 1'b1;
        n_inv    = present & ~onehot(req_id);
        n_store  = '0;
        n_store[ID_W-1:0] = req_id;
        n_cnt    = CNT_W'(1);
        n_rr     = '0;
        n_bcast  = 1'b0;
        n_coarse = 1'b0;
      end else if (present[req_id]) begin
        ev_hit = 1'b1;
      end else if (coarse) begin
        for (int g = 0; g < CV_W; g++)
          if ((32'(req_id) >> GRP_LOG) == 32'(g)) n_store[g] = 1'b1;
      end else if (!bcast && cnt < CNT_W'(NPTR)) begin
        ev_add = 1'b1;
        for (int k = 0; k < NPTR; k++)
          if (CNT_W'(k) == cnt) n_store[k*ID_W +: ID_W] = req_id;
        n_cnt = cnt + CNT_W'(1);
      end else begin
        ev_ovf = 1'b1;
        case (pol_e'(policy))
          POL_EVICT: begin
            ev_evict = 1'b1;
            for (int k = 0; k < NPTR; k++)
              if (RR_W'(k) == rr) begin
                n_inv = onehot(store[k*ID_W +: ID_W]);
                n_store[k*ID_W +: ID_W] = req_id;
              end
            n_rr = (rr == RR_W'(NPTR - 1)) ? '0 : rr + RR_W'(1);
          end
          POL_COARSE: begin
            n_store  = coarse_pack(present, req_id);
            n_coarse = 1'b1;
          end
          default: n_bcast = 1'b1;  // R11: codes 0 and 3
        endcase
      end
    end
  end
endmodule

// File: rtl/lpd_entry.sv
module lpd_entry
  import lpd_pkg::*;
#(
  parameter int NPROC     = 16,
  parameter int NPTR      = 2,
  localparam int ID_W     = $clog2(NPROC),
  localparam int CNT_W    = $clog2(NPTR + 1),
  localparam int CV_W     = NPTR * ID_W,
  localparam int RR_W     = (NPTR > 1) ? $clog2(NPTR) : 1,
  localparam int GRP_RAW  = (NPROC + CV_W - 1) / CV_W,
  localparam int GRP_LOG  = $clog2(GRP_RAW)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       policy,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [ID_W-1:0]  req_id,
  output logic             inv_valid,
  output logic [NPROC-1:0] inv_mask,
  output logic [CNT_W-1:0] sharer_cnt,
  output logic             ovf_bcast,
  output logic             ovf_coarse,
  output logic [CV_W-1:0]  ptr_bits,
  output logic [NPROC-1:0] present_mask
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(NPTR);

  logic [CV_W-1:0]  store_q, n_store;
  logic [CNT_W-1:0] cnt_q, n_cnt;
  logic [RR_W-1:0]  rr_q, n_rr;
  logic             bcast_q, coarse_q, n_bcast, n_coarse;
  logic [NPROC-1:0] n_inv, present;
  logic             ev_write, ev_hit, ev_add, ev_evict, ev_ovf;

  lpd_present #(.NPROC(NPROC), .NPTR(NPTR), .ID_W(ID_W), .CNT_W(CNT_W), .GRP_LOG(GRP_LOG))
  u_present (
    .store(store_q), .cnt(cnt_q), .bcast(bcast_q), .coarse(coarse_q), .present(present)
  );

  lpd_update #(.NPROC(NPROC), .NPTR(NPTR), .ID_W(ID_W), .CNT_W(CNT_W), .RR_W(RR_W),
               .GRP_LOG(GRP_LOG))
  u_update (
    .policy(policy), .req_valid(req_valid), .req_write(req_write), .req_id(req_id),
    .store(store_q), .cnt(cnt_q), .rr(rr_q), .bcast(bcast_q), .coarse(coarse_q),
    .present(present),
    .n_store(n_store), .n_cnt(n_cnt), .n_rr(n_rr), .n_bcast(n_bcast), .n_coarse(n_coarse),
    .n_inv(n_inv), .ev_write(ev_write), .ev_hit(ev_hit), .ev_add(ev_add),
    .ev_evict(ev_evict), .ev_ovf(ev_ovf)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      store_q   <= '0;
      cnt_q     <= '0;
      rr_q      <= '0;
      bcast_q   <= 1'b0;
      coarse_q  <= 1'b0;
      inv_valid <= 1'b0;
      inv_mask  <= '0;
    end else begin
      store_q   <= n_store;
      cnt_q     <= n_cnt;
      rr_q      <= n_rr;
      bcast_q   <= n_bcast;
      coarse_q  <= n_coarse;
      inv_valid <= |n_inv;
      inv_mask  <= n_inv;
    end
  end

  assign sharer_cnt   = cnt_q;
  assign ovf_bcast    = bcast_q;
  assign ovf_coarse   = coarse_q;
  assign ptr_bits     = store_q;
  assign present_mask = present;

  assert_cnt_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sharer_cnt <= CNT_MAX) && $onehot0({ovf_bcast, ovf_coarse}));

  assert_add_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_add |=> (sharer_cnt == $past(sharer_cnt) + CNT_W'(1)) && !inv_valid
               && present_mask[$past(req_id)]);

  assert_hit_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hit |=> $stable(ptr_bits) && $stable(sharer_cnt) && !inv_valid);

  assert_no_self_inv_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_write |=> !inv_mask[$past(req_id)]);

  assert_inv_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |-> $past(ev_write) || $past(ev_evict));

  assert_write_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_write |=> (sharer_cnt == CNT_W'(1)) && !ovf_bcast && !ovf_coarse
                 && (present_mask == (NPROC'(1) << $past(req_id))));

  assert_bcast_all_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_bcast |-> &present_mask);

  assert_evict_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_evict |=> ($countones(inv_mask) == 1) && present_mask[$past(req_id)]
                 && !inv_mask[$past(req_id)]);

  assert_coarse_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_write && ovf_coarse) |=> ($countones(inv_mask) < NPROC));

  assert_ovf_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_ovf && !ev_evict) |=> (ovf_bcast || ovf_coarse));
endmodule

// File: tb/sim_lpd_entry.sv
module sim_lpd_entry;
  localparam int NPROC = 16;
  localparam int NPTR  = 2;
  localparam int ID_W  = $clog2(NPROC);
  localparam int CNT_W = $clog2(NPTR + 1);
  localparam int CV_W  = NPTR * ID_W;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [1:0]       policy = 2'd0;
  logic             req_valid = 1'b0;
  logic             req_write = 1'b0;
  logic [ID_W-1:0]  req_id = '0;
  logic             inv_valid;
  logic [NPROC-1:0] inv_mask;
  logic [CNT_W-1:0] sharer_cnt;
  logic             ovf_bcast, ovf_coarse;
  logic [CV_W-1:0]  ptr_bits;
  logic [NPROC-1:0] present_mask;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  lpd_entry #(.NPROC(NPROC), .NPTR(NPTR)) u0 (
    .clk(clk), .rst_n(rst_n), .policy(policy), .req_valid(req_valid),
    .req_write(req_write), .req_id(req_id), .inv_valid(inv_valid), .inv_mask(inv_mask),
    .sharer_cnt(sharer_cnt), .ovf_bcast(ovf_bcast), .ovf_coarse(ovf_coarse),
    .ptr_bits(ptr_bits), .present_mask(present_mask)
  );

  // group size: smallest power of two not below ceil(NPROC / pointer bits)
  function automatic int grp_size();
    int need = (NPROC + CV_W - 1) / CV_W;
    int g = 1;
    while (g < need) g = g * 2;
    return g;
  endfunction

  // reference entry
  logic [CV_W-1:0] m_store;
  int m_cnt, m_rr;
  bit m_bc, m_cv;

  function automatic logic [NPROC-1:0] m_present();
    logic [NPROC-1:0] r = '0;
    if (m_bc) return '1;
    for (int p = 0; p < NPROC; p++) begin
      if (m_cv) r[p] = m_store[p / grp_size()];
    end
    if (!m_cv)
      for (int k = 0; k < m_cnt; k++) r[m_store[k*ID_W +: ID_W]] = 1'b1;
    return r;
  endfunction

  task automatic m_reset();
    m_store = '0; m_cnt = 0; m_rr = 0; m_bc = 0; m_cv = 0;
  endtask

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic do_reset(logic [1:0] pol);
    @(negedge clk);
    req_valid = 1'b0;
    rst_n = 1'b0;
    policy = pol;
    m_reset();
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 64'(sharer_cnt), 64'd0, "count after reset");
    check("R1", 64'(present_mask), 64'd0, "present after reset");
    check("R1", 64'({inv_valid, ovf_bcast, ovf_coarse}), 64'd0, "flags after reset");
  endtask

  task automatic req(bit w, int id);
    logic [NPROC-1:0] pres, exp_inv;
    string tag;
    pres = m_present();
    exp_inv = '0;
    tag = "R3";
    if (w) begin
      tag = "R4";
      exp_inv = pres;
      exp_inv[id] = 1'b0;
      m_store = '0; m_store[ID_W-1:0] = ID_W'(id);
      m_cnt = 1; m_rr = 0; m_bc = 0; m_cv = 0;
    end else if (pres[id]) begin
      tag = "R3";
    end else if (m_cv) begin
      tag = "R8";
      m_store[id / grp_size()] = 1'b1;
    end else if (m_cnt < NPTR) begin
      tag = "R2";
      m_store[m_cnt*ID_W +: ID_W] = ID_W'(id);
      m_cnt++;
    end else if (policy == 2'd1) begin
      tag = "R7";
      exp_inv[m_store[m_rr*ID_W +: ID_W]] = 1'b1;
      m_store[m_rr*ID_W +: ID_W] = ID_W'(id);
      m_rr = (m_rr + 1) % NPTR;
    end else if (policy == 2'd2) begin
      logic [CV_W-1:0] v = '0;
      tag = "R8";
      for (int p = 0; p < NPROC; p++) if (pres[p] || p == id) v[p / grp_size()] = 1'b1;
      m_store = v;
      m_cv = 1;
    end else begin
      tag = (policy == 2'd3) ? "R11" : "R6";
      m_bc = 1;
    end
    req_valid = 1'b1;
    req_write = w;
    req_id = ID_W'(id);
    @(negedge clk);
    req_valid = 1'b0;
    check(tag, 64'(inv_mask), 64'(exp_inv), "inv_mask");
    check(tag, 64'(inv_valid), 64'(exp_inv != '0), "inv_valid");
    check(w ? "R5" : tag, 64'(present_mask), 64'(m_present()), "present_mask");
    check(w ? "R5" : tag, 64'(ptr_bits), 64'(m_store), "ptr_bits");
    check("R10", 64'(sharer_cnt), 64'(m_cnt), "sharer_cnt");
    check("R10", 64'({ovf_bcast, ovf_coarse}), 64'({m_bc, m_cv}), "overflow flags");
    if (w && policy == 2'd2)
      check("R9", 64'($countones(inv_mask) <= NPROC - 1), 64'd1, "coarse inv count bound");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h1d3c);
    for (int pol = 0; pol < 4; pol++) begin
      do_reset(2'(pol));
      // directed: fill, repeat hit, overflow, write, refill, overflow again
      req(0, 3); req(0, 3); req(0, 5); req(0, 9); req(0, 9); req(0, 12);
      req(1, 5); req(0, 7); req(0, 11); req(0, 14); req(1, 0); req(1, 0);
      // write to an empty entry
      do_reset(2'(pol));
      req(1, 6);
      // coarse case where every sharer is in few groups
      req(0, 0); req(0, 1); req(1, 1);
      // random mix with a narrow id range to provoke hits and overflows
      for (int n = 0; n < 400; n++) begin
        int id = (($urandom % 4) == 0) ? int'($urandom % NPROC) : int'($urandom % 6);
        bit w = (($urandom % 5) == 0);
        if (($urandom % 8) == 0) @(negedge clk);
        req(w, id);
      end
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule